// File: doc/BRIEF.md
# RTC Output Waveform Generator

This block drives one output pin of a real-time-clock subsystem. A 3-bit source selector picks what appears on the pin: a constant low, one of four square waves derived from a single free-running divider, a signal built from the alarm flag (either toggling on each alarm rise or following the flag level), or a periodic pulse. For the pulse, a 3-bit code sets the high time and a 2-bit code sets the period.

The block runs from a clock-enable tick at 65.536 kHz, which is twice the 32.768 kHz crystal rate, so that the shortest pulse of one half-tick can be made. All timing is counted in these half-ticks. The output register only updates on a tick. A second instance serves a second pin. Oscillator generation and register access are handled elsewhere.

Top module: `rtc_wave_out`

## Requirements
- R1: While reset is asserted and after it is released, `wave_out` is 0 until the first tick.
- R2: With `src_sel` = 0, `wave_out` is 0 after every tick.
- R3: With `src_sel` = 1, 2, 3 or 4, `wave_out` after a tick equals bit 15, 10, 9 or 6 of the number of ticks since reset (modulo 65536). This gives square waves at 1 Hz, 32 Hz, 64 Hz and 512 Hz with a 50% duty cycle.
- R4: With `src_sel` = 5, `wave_out` inverts once for every rising edge of `alarm_flag`. Edges that occur between ticks take effect together at the next tick, so two rises between ticks leave the output unchanged.
- R5: With `src_sel` = 6, `wave_out` after a tick equals the level of `alarm_flag` at that tick.
- R6: With `src_sel` = 7, `wave_out` after a tick is 1 when the tick count modulo the period is below the high count, and 0 otherwise. `period_code` 0, 1, 2 and 3 give periods of 65536, 32768, 16384 and 8192 half-ticks (1 s, 500 ms, 250 ms and 125 ms).
- R7: `high_code` 0 to 7 give high counts of 2048, 1024, 256, 64, 32, 8, 2 and 1 half-ticks (about 31.2 ms down to 15.2 us).
- R8: `wave_out` changes only on a cycle where `tick_hf` is 1. A change of `src_sel` or of the codes takes effect at the next tick.
- R9: The toggle state for alarm mode follows every alarm rise, whichever source is selected. Selecting code 5 later shows the parity of all rises since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_hf | input | 1 | 65.536 kHz half-tick enable, one clock wide |
| src_sel | input | 3 | Output source selector |
| high_code | input | 3 | Pulse high-time code |
| period_code | input | 2 | Pulse period code |
| alarm_flag | input | 1 | Alarm flag level |
| wave_out | output | 1 | Selected waveform |

## Verification
An alarm rise can land in the same cycle as a tick, or in a cycle without one. In the first case the toggle must already be visible at that tick. In the second case it must wait for the following tick, and two rises inside one tick gap must cancel. The random phase varies tick gaps and alarm edges independently, and a directed case forces the double rise. A reference model that counts ticks and alarm rises judges every cycle.

// File: rtl/rtc_wave_out.sv
module rtc_wave_out #(
  parameter int SEC_BITS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_hf,
  input  logic [2:0] src_sel,
  input  logic [2:0] high_code,
  input  logic [1:0] period_code,
  input  logic       alarm_flag,
  output logic       wave_out
);
  localparam int W = SEC_BITS;

  logic [W-1:0] cnt_q, cnt_nx, phase, hi_len;
  logic         alarm_q, tog_q, tog_nx, wave_nx;

  assign cnt_nx = cnt_q + 1'b1;
  assign tog_nx = tog_q ^ (alarm_flag & ~alarm_q);
  assign phase  = cnt_nx & ({W{1'b1}} >> period_code);

  always_comb begin
    case (high_code)
      3'd0:    hi_len = W'(2048);
      3'd1:    hi_len = W'(1024);
      3'd2:    hi_len = W'(256);
      3'd3:    hi_len = W'(64);
      3'd4:    hi_len = W'(32);
      3'd5:    hi_len = W'(8);
      3'd6:    hi_len = W'(2);
      default: hi_len = W'(1);
    endcase
  end

  always_comb begin
    case (src_sel)
      3'd1:    wave_nx = cnt_nx[W-1];
      3'd2:    wave_nx = cnt_nx[W-6];
      3'd3:    wave_nx = cnt_nx[W-7];
      3'd4:    wave_nx = cnt_nx[W-10];
      3'd5:    wave_nx = tog_nx;
      3'd6:    wave_nx = alarm_flag;
      3'd7:    wave_nx = phase < hi_len;
      default: wave_nx = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      alarm_q  <= 1'b0;
      tog_q    <= 1'b0;
      wave_out <= 1'b0;
    end else begin
      alarm_q <= alarm_flag;
      tog_q   <= tog_nx;
      if (tick_hf) begin
        cnt_q    <= cnt_nx;
        wave_out <= wave_nx;
      end
    end
  end

  p_hold_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_hf |=> $stable(wave_out));

  p_zero_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_hf && src_sel == 3'd0) |=> !wave_out);

  p_alarm_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_hf && src_sel == 3'd6) |=> wave_out == $past(alarm_flag));

  p_out_known_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(wave_out));
endmodule

// File: tb/rtc_wave_out_test.sv
module rtc_wave_out_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick_hf = 1'b0, alarm_flag = 1'b0;
  logic [2:0] src_sel = 3'd0, high_code = 3'd0;
  logic [1:0] period_code = 2'd0;
  logic wave_out;

  int checks = 0, errors = 0, cyc = 0;
  logic [15:0] m_cnt = 16'd0;
  logic m_tog = 1'b0, m_alp = 1'b0, m_exp = 1'b0, m_prev = 1'b0, m_tick = 1'b0;
  logic [2:0] m_sel = 3'd0;
  bit run_chk = 1'b0, done = 1'b0;

  rtc_wave_out uut (.clk(clk), .rst_n(rst_n), .tick_hf(tick_hf), .src_sel(src_sel),
    .high_code(high_code), .period_code(period_code), .alarm_flag(alarm_flag),
    .wave_out(wave_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int hi_cnt(input logic [2:0] h);
    case (h)
      3'd0: return 2048; 3'd1: return 1024; 3'd2: return 256; 3'd3: return 64;
      3'd4: return 32;   3'd5: return 8;    3'd6: return 2;   default: return 1;
    endcase
  endfunction

  function automatic logic ref_wave(input logic [2:0] s, input logic [2:0] h,
      input logic [1:0] p, input logic [15:0] c, input logic tg, input logic al);
    int per;
    per = 65536 >> p;
    case (s)
      3'd0: return 1'b0;
      3'd1: return c[15];
      3'd2: return c[10];
      3'd3: return c[9];
      3'd4: return c[6];
      3'd5: return tg;
      3'd6: return al;
      default: return (int'(c) % per) < hi_cnt(h);
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] s, input logic t);
    if (!t) return "R8";
    case (s)
      3'd0: return "R2";
      3'd5: return "R4";
      3'd6: return "R5";
      3'd7: return "R6";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: wave_out=%b expected=%b (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always begin
    @(posedge clk);
    cyc++;
    m_prev = m_exp;
    m_sel = src_sel;
    m_tick = tick_hf;
    if (!rst_n) begin
      m_cnt = 16'd0; m_tog = 1'b0; m_alp = 1'b0; m_exp = 1'b0;
    end else begin
      if (alarm_flag && !m_alp) m_tog = ~m_tog;
      m_alp = alarm_flag;
      if (tick_hf) begin
        m_cnt = m_cnt + 16'd1;
        m_exp = ref_wave(src_sel, high_code, period_code, m_cnt, m_tog, alarm_flag);
      end
    end
    #1;
    if (run_chk) check(tag_of(m_sel, m_tick), wave_out, m_exp);
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int hi;
    void'($urandom(32'd20240611));
    cycles(3);
    check("R1", wave_out, 1'b0);
    rst_n = 1'b1;
    cycles(2);
    check("R1", wave_out, 1'b0);
    run_chk = 1'b1;

    // R8: selector changed with no tick keeps output
    src_sel = 3'd6; alarm_flag = 1'b1;
    cycles(3);
    check("R8", wave_out, 1'b0);
    tick_hf = 1'b1;
    cycles(1);
    check("R5", wave_out, 1'b1);

    // R4 double rise between ticks, then single rise with a tick
    src_sel = 3'd5; alarm_flag = 1'b0;
    cycles(1);
    hi = wave_out;
    tick_hf = 1'b0;
    alarm_flag = 1'b1; cycles(1); alarm_flag = 1'b0; cycles(1);
    alarm_flag = 1'b1; cycles(1); alarm_flag = 1'b0;
    tick_hf = 1'b1; cycles(1);
    check("R4", wave_out, hi[0]);
    alarm_flag = 1'b1; cycles(1);
    check("R4", wave_out, ~hi[0]);

    // R9: rises seen while source 0 is selected
    src_sel = 3'd0; alarm_flag = 1'b0; cycles(1);
    alarm_flag = 1'b1; cycles(1);
    check("R9", wave_out, 1'b0);
    alarm_flag = 1'b0;
    src_sel = 3'd5; cycles(1);
    check("R9", wave_out, hi[0]);

    // random mix
    for (int i = 0; i < 10000; i++) begin
      if ($urandom_range(63) == 0) begin
        src_sel = 3'($urandom_range(7));
        high_code = 3'($urandom_range(7));
        period_code = 2'($urandom_range(3));
      end
      if ($urandom_range(15) == 0) alarm_flag = ~alarm_flag;
      tick_hf = ($urandom_range(7) != 0);
      cycles(1);
    end

    // R7: high count per 125 ms period
    tick_hf = 1'b1; src_sel = 3'd7; period_code = 2'd3;
    for (int h = 0; h < 8; h++) begin
      high_code = 3'(h);
      hi = 0;
      for (int k = 0; k < 8192; k++) begin
        cycles(1);
        hi += int'(wave_out);
      end
      checks++;
      if (hi != hi_cnt(3'(h))) begin
        errors++;
        $display("FAIL R7: code %0d high=%0d expected=%0d", h, hi, hi_cnt(3'(h)));
      end
    end

    // R3: 1 Hz duty over one full second
    src_sel = 3'd1;
    hi = 0;
    for (int k = 0; k < 65536; k++) begin
      cycles(1);
      hi += int'(wave_out);
    end
    checks++;
    if (hi != 32768) begin
      errors++;
      $display("FAIL R3: 1 Hz high=%0d expected=32768", hi);
    end

    run_chk = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (195000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule